// File: doc/BRIEF.md
# Bus Wait-State Generator

This block stretches microcontroller bus cycles by 0 to 7 wait states, chosen by the 256-byte page being accessed. It runs from the rising edge of the processor clock output. When a cycle starts, it looks at the upper address byte (address bits 15 to 8), a stretched address strobe and a hold-acknowledge input. A region that needs wait states pulls the active-low `wait_n` low straight away, through logic alone. A small 3-bit state machine then keeps `wait_n` low for the rest of the programmed count and ends in a release state that forces it high.

The processor samples its ready pin on the falling clock edge. For that reason a second output, `ready_wait_n`, is retimed by a falling-edge flop. While the strobe is high it also follows `wait_n` directly. An external wait request from an expansion bus feeds the same falling-edge flop. The wait count of each region is set by a parameter. The defaults are: one wait state for the two monitor pages, two for the serial-controller page, one for pages 80h to BFh, and none for any other page.

Top module: `bus_wait_fsm`

## Requirements
- R1: While reset is applied, the machine sits in its idle state and `ready_wait_n` is high. `wait_n` then depends only on the address page.
- R2: The machine leaves idle only when all three hold: `strobe` is high, `hold_ack` is low, and the page needs at least one wait state. While `hold_ack` is high, a waited page keeps `wait_n` low and no release cycle ever comes.
- R3: A page with zero wait states never drives `wait_n` low, and the machine stays idle even with `strobe` high.
- R4: For a page with one wait state, `wait_n` is low in the strobe cycle. In the next cycle it is high (the release state), whatever the address.
- R5: For a page with n wait states (n from 2 to 7), `wait_n` is low in the strobe cycle and in the n-1 hold cycles after it. It is then high for exactly one release cycle, even if the address still needs wait states.
- R6: One clock edge after the release cycle, the machine is idle again, and `wait_n` once more follows the address page combinationally.
- R7: `ready_wait_n` is low at once while `strobe` is high and `wait_n` is low. Apart from that, each falling clock edge samples whether `wait_n` is low or `ext_wait` is high, and `ready_wait_n` shows the inverse of that sample until the next falling edge.
- R8: When `ext_wait` is high at a falling edge, `ready_wait_n` is low from that edge until the next falling edge, even with `wait_n` high.
- R9: The wait count is chosen from `addr_hi`:
  - pages 00h and 1Dh use `WS_MON` (default 1);
  - page 1Eh uses `WS_UART` (default 2);
  - pages 80h to BFh (`addr_hi[7:6]` = 10b) use `WS_EXT` (default 1);
  - every other page uses zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock output; the state machine runs on its rising edge, the retiming flop on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| strobe | input | 1 | Stretched address strobe, active high; stays high until after the next rising edge |
| hold_ack | input | 1 | Bus hold acknowledge, active high; blocks the start of a wait sequence |
| addr_hi | input | 8 | Latched address bits 15 to 8 |
| ext_wait | input | 1 | External wait request from the expansion bus, active high |
| wait_n | output | 1 | Wait request, active low; combinational in the idle state |
| ready_wait_n | output | 1 | Wait request to the processor ready pin, active low, retimed on the falling edge |

## Verification
Two instances run side by side on the same inputs. One has the default counts. The other has counts of 3, 7 and 5, so the longest hold chain is covered and each region can be told apart from the others.

Accesses are made to every region boundary page. Some accesses move the address to a waited page during the hold and release cycles, which shows that the release is forced high and not decoded from the address. Others return to a zero-wait page, which shows the machine is back in idle. A strobe held together with hold acknowledge shows that the sequence never starts. A lone external request shows the one-falling-edge latency of the retimed output. The retimed output is sampled both before and after the falling edge, so its combinational path and its flop path are checked separately.

// File: rtl/bus_wait_fsm.sv
module bus_wait_fsm #(
  parameter logic [2:0] WS_MON    = 3'd1,
  parameter logic [2:0] WS_UART   = 3'd2,
  parameter logic [2:0] WS_EXT    = 3'd1,
  parameter logic [7:0] MON_PAGE0 = 8'h00,
  parameter logic [7:0] MON_PAGE1 = 8'h1D,
  parameter logic [7:0] UART_PAGE = 8'h1E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe,
  input  logic       hold_ack,
  input  logic [7:0] addr_hi,
  input  logic       ext_wait,
  output logic       wait_n,
  output logic       ready_wait_n
);
  localparam logic [2:0] IDLE = 3'd0;
  localparam logic [2:0] REL  = 3'd1;
  localparam logic [2:0] HOLD = 3'd2;

  logic [2:0] state, limit, need;
  logic       in_idle, held;

  always_comb begin
    if (addr_hi == MON_PAGE0 || addr_hi == MON_PAGE1) need = WS_MON;
    else if (addr_hi == UART_PAGE)                    need = WS_UART;
    else if (addr_hi[7:6] == 2'b10)                   need = WS_EXT;
    else                                              need = 3'd0;
  end

  assign in_idle = (state == IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE;
      limit <= 3'd0;
    end else begin
      case (state)
        IDLE: if (strobe && !hold_ack && need != 3'd0) begin
          limit <= need;
          state <= (need == 3'd1) ? REL : HOLD;
        end
        REL:     state <= IDLE;
        default: state <= (state >= limit) ? REL : state + 3'd1;
      endcase
    end
  end

  assign wait_n = in_idle ? (need == 3'd0) : (state == REL);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) held <= 1'b0;
    else        held <= !wait_n || ext_wait;
  end

  assign ready_wait_n = !(held || (strobe && !wait_n));
endmodule

module bus_wait_fsm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       strobe,
  input logic       hold_ack,
  input logic       ext_wait,
  input logic       wait_n,
  input logic       ready_wait_n,
  input logic [2:0] state
);
  assert_hold_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0 && hold_ack) |=> state == 3'd0);
  assert_zero_stays_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0 && wait_n) |=> state == 3'd0);
  assert_release_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd1) |-> wait_n);
  assert_hold_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state >= 3'd2) |-> !wait_n);
  assert_release_returns_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd1) |=> state == 3'd0);
  assert_strobe_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !wait_n) |-> !ready_wait_n);
  assert_ext_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wait |-> !ready_wait_n);
endmodule

bind bus_wait_fsm bus_wait_fsm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .strobe(strobe), .hold_ack(hold_ack),
  .ext_wait(ext_wait), .wait_n(wait_n), .ready_wait_n(ready_wait_n),
  .state(state)
);

// File: tb/sim_bus_wait_fsm.sv
module sim_bus_wait_fsm;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, strobe = 1'b0, hold_ack = 1'b0, ext_wait = 1'b0;
  logic [7:0] addr_hi = 8'h30;
  logic w0, r0, w1, r1;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  bit [5:0] q_exp[$];
  string    q_tag[$];
  bit [1:0] prev_w = 2'b00;
  bit       prev_e = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_wait_fsm u0 (.clk(clk), .rst_n(rst_n), .strobe(strobe), .hold_ack(hold_ack),
    .addr_hi(addr_hi), .ext_wait(ext_wait), .wait_n(w0), .ready_wait_n(r0));
  bus_wait_fsm #(.WS_MON(3'd3), .WS_UART(3'd7), .WS_EXT(3'd5)) u1 (.clk(clk),
    .rst_n(rst_n), .strobe(strobe), .hold_ack(hold_ack), .addr_hi(addr_hi),
    .ext_wait(ext_wait), .wait_n(w1), .ready_wait_n(r1));

  function automatic int ws(bit [7:0] a, int mon, int uart, int ext);
    if (a == 8'h00 || a == 8'h1D) return mon;
    if (a == 8'h1E) return uart;
    if (a >= 8'h80 && a <= 8'hBF) return ext;
    return 0;
  endfunction

  task automatic chk(logic got, bit exp, string tag, string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic step(bit s, bit h, bit [7:0] a, bit e, bit [1:0] w, string tag);
    bit [1:0] re, rl;
    @(posedge clk); #2;
    strobe = s; hold_ack = h; addr_hi = a; ext_wait = e;
    for (int k = 0; k < 2; k++) begin
      re[k] = !(prev_w[k] || prev_e || (s && w[k]));
      rl[k] = !(w[k] || e);
    end
    q_exp.push_back({re, rl, ~w});
    q_tag.push_back(tag);
    prev_w = w; prev_e = e;
  endtask

  task automatic access(bit [7:0] a, bit [7:0] a2, string tag);
    int n[2], m[2], len;
    bit [1:0] w;
    n[0] = ws(a, 1, 2, 1);  n[1] = ws(a, 3, 7, 5);
    m[0] = ws(a2, 1, 2, 1); m[1] = ws(a2, 3, 7, 5);
    len = ((n[0] > n[1]) ? n[0] : n[1]) + 2;
    for (int j = 0; j < len; j++) begin
      for (int k = 0; k < 2; k++)
        if (j == 0)        w[k] = n[k] > 0;
        else if (j < n[k]) w[k] = 1'b1;
        else if (j == n[k]) w[k] = 1'b0;
        else               w[k] = m[k] > 0;
      step(j == 0, 1'b0, (j == 0) ? a : a2, 1'b0, w, tag);
    end
  endtask

  initial begin : monitor
    bit [5:0] x;
    string t;
    forever begin
      @(posedge clk); #3;
      if (q_exp.size() > 0) begin
        x = q_exp.pop_front(); t = q_tag.pop_front();
        chk(r0, x[4], t, "R7 early ready u0");
        chk(r1, x[5], t, "R7 early ready u1");
        #5;
        chk(w0, x[0], t, "wait_n u0");
        chk(w1, x[1], t, "wait_n u1");
        chk(r0, x[2], t, "R7 late ready u0");
        chk(r1, x[3], t, "R7 late ready u1");
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    addr_hi = 8'h1E;
    repeat (3) @(posedge clk);
    #8;
    chk(w0, 1'b0, "R1", "wait_n follows page in reset");
    chk(r0, 1'b1, "R1", "ready_wait_n cleared in reset");
    chk(r1, 1'b1, "R1", "ready_wait_n cleared in reset u1");
    addr_hi = 8'h30;
    @(posedge clk); #2; rst_n = 1'b1;

    step(0, 0, 8'h30, 0, 2'b00, "R1");
    access(8'h50, 8'h50, "R3");
    access(8'h7F, 8'h30, "R3");
    access(8'h00, 8'h30, "R4");
    access(8'h1D, 8'h00, "R4");
    access(8'h1E, 8'h1E, "R5");
    access(8'h1E, 8'h30, "R6");
    access(8'h80, 8'h30, "R9");
    access(8'hBF, 8'h1D, "R9");
    access(8'hC0, 8'h30, "R9");
    access(8'h1F, 8'h30, "R9");
    access(8'h20, 8'h30, "R9");

    for (int i = 0; i < 4; i++) step(1, 1, 8'h1E, 0, 2'b11, "R2");
    step(0, 1, 8'h30, 0, 2'b00, "R2");
    step(0, 0, 8'h30, 0, 2'b00, "R2");
    access(8'h30, 8'h30, "R2");

    step(0, 0, 8'h30, 1, 2'b00, "R8");
    step(0, 0, 8'h30, 0, 2'b00, "R8");
    step(0, 0, 8'h30, 0, 2'b00, "R8");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule